// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register file. Software sets each pin's output value and direction, reads back the synchronized level of every pad, and picks one of four trigger conditions per pin. The conditions are low level, high level, rising edge and falling edge.

When a pin's condition is detected, the block latches it into a status register. Software clears status bits by writing ones to them. A mask register gates status onto three registered interrupt lines: one for the lower half of the pins, one for the upper half, and one that combines both.

The bus is a plain single-cycle interface. An access uses a byte address, write data, a write strobe and a read strobe. Read data is registered.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data-out, direction, mask, both trigger-config and interrupt outputs are zero, and pad_out and pad_oe are zero.
- R2: The data-out register (address 0x00) drives pad_out and the direction register (address 0x04) drives pad_oe. A direction bit of 1 makes the pin an output. Both registers read back what was written.
- R3: The pad-status register (address 0x08) reads the level of pad_in after a two-flop synchronizer, whatever the pin's direction. Writes to it are ignored.
- R4: Trigger config for pins 0..15 is at address 0x0C and for pins 16..31 at address 0x10. The 2-bit field of pin n sits at bits [2*(n mod 16)+1 : 2*(n mod 16)]. Both registers read back what was written.
- R5: Trigger code 0 is low level and code 1 is high level. A level trigger sets the pin's status bit on every cycle the level holds, so a clear while the level persists leaves the bit set.
- R6: Trigger code 2 is rising edge and code 3 is falling edge. An edge trigger sets the status bit once per matching edge. After a clear, the bit stays zero until the next matching edge.
- R7: The status register (address 0x18) is write-one-to-clear. Writing 0 to a bit leaves it unchanged.
- R8: When a detected condition and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The mask register is at address 0x14, and a mask bit of 1 enables its pin. irq_lo is the registered OR of status AND mask over pins 0..15, and irq_hi is the same over pins 16..31. Each follows status one cycle later.
- R10: irq_any is registered and equals irq_lo OR irq_hi.
- R11: bus_rdata is loaded on the clock edge where bus_re is high, with the addressed register. Unmapped word addresses (0x1C) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Output values to the pads |
| pad_oe | output | 32 | Output enables (1 = drive) |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |
| irq_any | output | 1 | Interrupt for any pin |

## Verification
The hardest situation to reach from the ports is a pad edge and a write-one-to-clear landing on the same status bit in the same clock cycle. The bench reaches it by driving the pad and then counting exactly the two synchronizer edges before it issues the clearing write. The write then meets the detection on the third edge.

Random phases change trigger configs, masks and pad patterns from a fixed seed. After each change the bench clears status and lets it settle, so that a bench model of level and edge hits predicts the status and interrupt lines. Directed cases cover a level that persists through a clear, an edge whose status stays cleared, and an unmapped read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word index of each register (byte address >> 2)
  localparam int IDX_DOUT = 0;
  localparam int IDX_DIR  = 1;
  localparam int IDX_PAD  = 2;
  localparam int IDX_CFGL = 3;
  localparam int IDX_CFGH = 4;
  localparam int IDX_MASK = 5;
  localparam int IDX_STAT = 6;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta   <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]   cur,
  input  logic [NPINS-1:0]   prev,
  input  logic [2*NPINS-1:0] cfg,
  output logic [NPINS-1:0]   hit
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    trig_e mode;
    assign mode = trig_e'(cfg[2*n +: 2]);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  hit[n] = ~cur[n];
        TRIG_HIGH: hit[n] = cur[n];
        TRIG_RISE: hit[n] = cur[n] & ~prev[n];
        TRIG_FALL: hit[n] = ~cur[n] & prev[n];
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] clr,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] status,
  output logic             irq_lo,
  output logic             irq_hi,
  output logic             irq_any
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] pend;
  assign pend = status & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      irq_lo  <= 1'b0;
      irq_hi  <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      // a detected condition outranks a clear on the same bit
      status  <= (status & ~clr) | hit;
      irq_lo  <= |pend[HALF-1:0];
      irq_hi  <= |pend[NPINS-1:HALF];
      irq_any <= |pend;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_any
);
  localparam int HALF  = NPINS / 2;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  widx;
  logic [NPINS-1:0]  dout_q, dir_q, mask_q;
  logic [2*HALF-1:0] cfg_lo_q, cfg_hi_q;
  logic [NPINS-1:0]  pad_s, pad_p, hit, clr, status;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
  assign clr     = (bus_we && widx == IDX_W'(IDX_STAT)) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else if (bus_we) begin
      if (widx == IDX_W'(IDX_DOUT)) dout_q   <= bus_wdata;
      if (widx == IDX_W'(IDX_DIR))  dir_q    <= bus_wdata;
      if (widx == IDX_W'(IDX_MASK)) mask_q   <= bus_wdata;
      if (widx == IDX_W'(IDX_CFGL)) cfg_lo_q <= bus_wdata[2*HALF-1:0];
      if (widx == IDX_W'(IDX_CFGH)) cfg_hi_q <= bus_wdata[2*HALF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if      (widx == IDX_W'(IDX_DOUT)) bus_rdata <= dout_q;
      else if (widx == IDX_W'(IDX_DIR))  bus_rdata <= dir_q;
      else if (widx == IDX_W'(IDX_PAD))  bus_rdata <= pad_s;
      else if (widx == IDX_W'(IDX_CFGL)) bus_rdata <= NPINS'(cfg_lo_q);
      else if (widx == IDX_W'(IDX_CFGH)) bus_rdata <= NPINS'(cfg_hi_q);
      else if (widx == IDX_W'(IDX_MASK)) bus_rdata <= mask_q;
      else if (widx == IDX_W'(IDX_STAT)) bus_rdata <= status;
      else                               bus_rdata <= '0;
    end
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_s), .q_prev(pad_p)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_det (
    .cur(pad_s), .prev(pad_p), .cfg({cfg_hi_q, cfg_lo_q}), .hit(hit)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_stat (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .mask(mask_q),
    .status(status), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_we,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  status,
  input logic [NPINS-1:0]  clr,
  input logic [NPINS-1:0]  mask_q,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic              irq_any
);
  localparam int HALF = NPINS / 2;
  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  assert_dout_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && widx == 0) |=> pad_out == $past(bus_wdata));

  assert_dir_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && widx == 1) |=> pad_oe == $past(bus_wdata));

  assert_w1c_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(status) & ~$past(clr) & ~status) == '0));

  assert_irq_lo_R9: assert property (@(posedge clk) disable iff (rst)
    irq_lo == $past(|(status[HALF-1:0] & mask_q[HALF-1:0])));

  assert_irq_hi_R9: assert property (@(posedge clk) disable iff (rst)
    irq_hi == $past(|(status[NPINS-1:HALF] & mask_q[NPINS-1:HALF])));

  assert_irq_any_R10: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_lo | irq_hi));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .pad_out(pad_out), .pad_oe(pad_oe), .status(status),
  .clr(clr), .mask_q(mask_q), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .irq_any(irq_any)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_any;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );

  localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
    A_CFGL = 5'h0C, A_CFGH = 5'h10, A_MASK = 5'h14, A_STAT = 5'h18,
    A_NONE = 5'h1C;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of trigger hits (codes: 0 low, 1 high, 2 rise, 3 fall)
  function automatic logic [31:0] lvl(input logic [31:0] p, input logic [63:0] cfg);
    logic [31:0] h;
    for (int n = 0; n < 32; n++)
      h[n] = (cfg[2*n +: 2] == 2'd0 && !p[n]) || (cfg[2*n +: 2] == 2'd1 && p[n]);
    return h;
  endfunction

  function automatic logic [31:0] edg(input logic [31:0] o, input logic [31:0] p,
                                      input logic [63:0] cfg);
    logic [31:0] h;
    for (int n = 0; n < 32; n++)
      h[n] = (cfg[2*n +: 2] == 2'd2 && !o[n] && p[n]) ||
             (cfg[2*n +: 2] == 2'd3 && o[n] && !p[n]);
    return h;
  endfunction

  task automatic chk_irq(input string req, input logic [31:0] st, input logic [31:0] m);
    logic [31:0] pm;
    pm = st & m;
    chk(req, {29'd0, irq_any, irq_hi, irq_lo},
        {29'd0, |pm, |pm[31:16], |pm[15:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] d, st, m, old, w;
    logic [63:0] cfg;
    void'($urandom(32'd1234));
    idle(3);
    rst = 1'b0;
    idle(4);

    // R1 reset state
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {29'd0, irq_any, irq_hi, irq_lo}, 0);
    rd(A_DOUT, d); chk("R1 dout", d, 0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_CFGL, d); chk("R1 cfg_lo", d, 0);
    // R5 default code 0 = low level with pads low: every status bit set
    rd(A_STAT, d); chk("R5 low level after reset", d, 32'hFFFF_FFFF);

    // R2 data-out and direction
    wr(A_DOUT, 32'hA5A5_0F0F); wr(A_DIR, 32'h0000_FFFF);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    rd(A_DIR, d); chk("R2 dir readback", d, 32'h0000_FFFF);

    // R3 pad status regardless of direction, writes ignored
    pad_in = 32'h1234_8001; idle(3);
    rd(A_PAD, d); chk("R3 pad status", d, 32'h1234_8001);
    wr(A_PAD, 32'hFFFF_FFFF);
    rd(A_PAD, d); chk("R3 pad write ignored", d, 32'h1234_8001);

    // R4 config layout: low pins rising (2), high pins falling (3)
    pad_in = 32'h0; idle(3);
    wr(A_CFGL, 32'hAAAA_AAAA); wr(A_CFGH, 32'hFFFF_FFFF);
    rd(A_CFGH, d); chk("R4 cfg_hi readback", d, 32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF); idle(2);
    rd(A_STAT, d); chk("R7 cleared", d, 0);

    // R6 rising on pin 4, falling on pin 20
    pad_in = 32'h0010_0010; idle(6);
    rd(A_STAT, d); chk("R6 rising pin4", d, 32'h0000_0010);
    pad_in = 32'h0; idle(6);
    rd(A_STAT, d); chk("R6 falling pin20", d, 32'h0010_0010);
    // R7 zero write leaves bits
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R7 zero write", d, 32'h0010_0010);
    // R9 mask gating, split halves
    wr(A_MASK, 32'h0010_0000); idle(2);
    chk("R9 irq_hi only", {29'd0, irq_any, irq_hi, irq_lo}, 32'd6);
    chk("R10 irq_any", {31'd0, irq_any}, 1);
    wr(A_STAT, 32'h0010_0010); idle(6);
    rd(A_STAT, d); chk("R6 edge stays cleared", d, 0);
    chk("R9 irq after clear", {29'd0, irq_any, irq_hi, irq_lo}, 0);

    // R5 level persists through clear: pin 3 high level
    wr(A_CFGL, 32'hAAAA_AA6A);
    pad_in = 32'h0000_0008; idle(6);
    wr(A_STAT, 32'hFFFF_FFFF); idle(2);
    rd(A_STAT, d); chk("R5 level persists", d, 32'h0000_0008);
    wr(A_MASK, 32'h0000_0008); idle(2);
    chk("R9 irq_lo only", {29'd0, irq_any, irq_hi, irq_lo}, 32'd5);

    // R8 edge and clear in the same cycle on pin 5 (rising)
    pad_in = 32'h0; idle(4);
    wr(A_CFGL, 32'hAAAA_AAAA); wr(A_STAT, 32'hFFFF_FFFF); idle(2);
    @(negedge clk); pad_in = 32'h0000_0020;
    @(negedge clk);
    @(negedge clk); bus_addr = A_STAT; bus_wdata = 32'h0000_0020; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    idle(3);
    rd(A_STAT, d); chk("R8 set wins over clear", d, 32'h0000_0020);

    // R11 unmapped read
    rd(A_NONE, d); chk("R11 unmapped read", d, 0);

    // random phase against the bench model
    old = pad_in;
    for (int it = 0; it < 40; it++) begin
      cfg = {$urandom(), $urandom()};
      m   = $urandom();
      wr(A_CFGL, cfg[31:0]); wr(A_CFGH, cfg[63:32]); idle(3);
      wr(A_STAT, 32'hFFFF_FFFF); idle(3);
      st = lvl(old, cfg);
      wr(A_MASK, m);
      d = $urandom();
      pad_in = d; idle(6);
      st = st | edg(old, d, cfg) | lvl(d, cfg);
      old = d;
      rd(A_STAT, d); chk("R5 R6 random status", d, st);
      chk_irq("R9 R10 random irq", st, m);
      w = $urandom();
      wr(A_STAT, w); idle(3);
      st = (st & ~w) | lvl(old, cfg);
      rd(A_STAT, d); chk("R7 random clear", d, st);
      chk_irq("R9 random irq after clear", st, m);
    end
    report();
  end
endmodule